// File: doc/BRIEF.md
# Multiplexed Flash Bus Device Front End

This block is the device side of an 8-bit flash bus on which commands, addresses and data share a single byte-wide port. The level of two latch-select pins at the rising edge of the write strobe decides what a byte is. With the command select high, the byte is an operation code. With the address select high, it is part of an address. With both low, it is write data. A read strobe pulls bytes out one at a time, and each falling edge advances an internal column pointer.

In place of a real cell array the block holds a small paged store and a page register. A read, program or erase request keeps the device busy for a number of clock cycles set by an input. During that time the device pulls its ready/busy line low and refuses everything except a status query. The device drops into standby when chip select is released while it is ready. A low write-protect pin makes program and erase requests do nothing.

The bus is paced entirely by the host's strobes. There is no back-pressure: the host must poll the ready/busy line or the status byte before it issues the next operation. All pins are sampled on `clk`, so the strobes must each stay at a level for at least two clock cycles. The command, address and data levels must be held one cycle past the write strobe's rising edge.

Top module: `nfe_bus_front`

## Requirements
- R1: A byte is taken as a command on a write-strobe rising edge when chip select is low, the command select is high and the address select is low. The codes used are 0x00/0x30 (read setup/go), 0x80/0x10 (program setup/go), 0x60/0xD0 (erase setup/go) and 0x70 (status). Any other code returns the device to idle. A go code issued outside its own setup phase starts nothing.
- R2: A write-strobe cycle with both command select and address select high is ignored completely.
- R3: Address bytes are consumed in order: COL_BYTES column bytes, then ROW_BYTES row bytes. Bytes beyond that count are ignored. Every accepted command restarts the sequence. After an erase setup, the sequence starts at the first row byte.
- R4: In the program phase, a write-strobe cycle with both selects low stores the byte into the page register at the current column, and the column then increments by one.
- R5: After read go completes, each read-strobe falling edge with chip select low puts the page-register byte at the current column on `io_out` and increments the column. The column index wraps modulo PAGE_BYTES.
- R6: A read go, or a permitted program go or erase go, drives `rb_pull_low` high for max(`busy_len`,1) clock cycles. Read copies the addressed page into the page register, program copies the page register into the page, and erase fills the page with 0xFF.
- R7: While busy, every write-strobe cycle is ignored except the status command 0x70.
- R8: The status byte has bit 7 equal to the write-protect pin level (1 means writes allowed) and bit 6 equal to ready; all other bits are 0. Reads after a 0x70 return this byte until the next command.
- R9: With `wp_n` low, program go and erase go start no busy period and leave the stored pages unchanged.
- R10: An erase leaves every byte of the addressed page reading 0xFF, and other pages are untouched.
- R11: `standby` is high exactly when chip select is high and the device is ready. A high chip select during busy neither ends the operation nor raises `standby`.
- R12: `io_oe` is high only when chip select and the read strobe are both low (one sampling cycle earlier) and the device is in a data-out or status-out phase.
- R13: After reset every page reads 0xFF, the device is ready, and `io_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| re_n | input | 1 | Read strobe, byte presented after its falling edge |
| wp_n | input | 1 | Write protect, low blocks program and erase |
| io_in | input | 8 | Bus byte driven by the host |
| busy_len | input | TIMER_W | Busy period length in clock cycles |
| io_out | output | 8 | Byte presented to the host |
| io_oe | output | 1 | Output driver enable for `io_out` |
| rb_pull_low | output | 1 | Ready/busy pull-down, high while busy |
| standby | output | 1 | Low-power standby indication |

## Verification
The bench fills every page with an arithmetic pattern. It then reads each page back from several start columns, running past the page end. A column counter that fails to wrap, or that steps on a read strobe while chip select is high, returns the wrong byte. Busy periods are timed for lengths zero through several cycles, which exposes an off-by-one in the timer. Illegal and unknown commands, surplus address bytes and a restarted address sequence are each aimed at a decoder that would otherwise start a busy period or latch the wrong page or column. Write protection, status during busy, erase isolation and standby under busy are each probed at the pins: a design that ignored any of these rules would either start a busy period or change stored data.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

  localparam logic [7:0] OPC_READ     = 8'h00;
  localparam logic [7:0] OPC_READ_GO  = 8'h30;
  localparam logic [7:0] OPC_PROG     = 8'h80;
  localparam logic [7:0] OPC_PROG_GO  = 8'h10;
  localparam logic [7:0] OPC_ERASE    = 8'h60;
  localparam logic [7:0] OPC_ERASE_GO = 8'hD0;
  localparam logic [7:0] OPC_STATUS   = 8'h70;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RD_ADDR, PH_PG_LOAD, PH_ER_ADDR, PH_DATA_OUT, PH_STAT_OUT
  } phase_t;

  typedef enum logic [1:0] {OP_NONE, OP_FETCH, OP_WRITE, OP_WIPE} op_t;

  typedef enum logic [1:0] {CYC_NONE, CYC_CMD, CYC_ADDR, CYC_DATA} cyc_t;

endpackage

// File: rtl/nfe_pin_sampler.sv
module nfe_pin_sampler
  import nfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output cyc_t       cyc,
  output logic [7:0] bus_byte,
  output logic       re_fall,
  output logic       re_low,
  output logic       ce_low,
  output logic       wp_ok
);

  logic we_q, we_qq, re_q, re_qq, cle_q, ale_q, ce_q, wp_q;
  logic [7:0] io_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b1;
      we_qq <= 1'b1;
      re_q  <= 1'b1;
      re_qq <= 1'b1;
      cle_q <= 1'b0;
      ale_q <= 1'b0;
      ce_q  <= 1'b1;
      wp_q  <= 1'b0;
      io_q  <= 8'h00;
    end else begin
      we_q  <= we_n;
      we_qq <= we_q;
      re_q  <= re_n;
      re_qq <= re_q;
      cle_q <= cle;
      ale_q <= ale;
      ce_q  <= ce_n;
      wp_q  <= wp_n;
      io_q  <= io_in;
    end
  end

  logic we_rise;
  assign we_rise = we_q & ~we_qq & ~ce_q;

  always_comb begin
    cyc = CYC_NONE;
    if (we_rise) begin
      if (cle_q && ale_q)  cyc = CYC_NONE;
      else if (cle_q)      cyc = CYC_CMD;
      else if (ale_q)      cyc = CYC_ADDR;
      else                 cyc = CYC_DATA;
    end
  end

  assign bus_byte = io_q;
  assign re_fall  = ~re_q & re_qq & ~ce_q;
  assign re_low   = ~re_q;
  assign ce_low   = ~ce_q;
  assign wp_ok    = wp_q;

endmodule

// File: rtl/nfe_busy_timer.sv
module nfe_busy_timer #(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TIMER_W-1:0] len,
  output logic               busy,
  output logic               done
);

  logic [TIMER_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start && !busy) begin
      cnt <= (len == '0) ? TIMER_W'(1) : len;
    end else if (cnt != '0) begin
      cnt <= cnt - TIMER_W'(1);
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == TIMER_W'(1));

endmodule

// File: rtl/nfe_addr_unit.sv
module nfe_addr_unit #(
  parameter int COL_BYTES = 1,
  parameter int ROW_BYTES = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seq_restart,
  input  logic                   seq_rows_only,
  input  logic                   addr_wipe,
  input  logic                   addr_en,
  input  logic [7:0]             bus_byte,
  input  logic                   col_step,
  output logic [8*COL_BYTES-1:0] col,
  output logic [8*ROW_BYTES-1:0] row
);

  localparam int NB = COL_BYTES + ROW_BYTES;
  localparam int IW = $clog2(NB + 1);

  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      col <= '0;
      row <= '0;
    end else begin
      if (seq_restart) begin
        idx <= seq_rows_only ? IW'(COL_BYTES) : '0;
        if (addr_wipe) begin
          col <= '0;
          row <= '0;
        end
      end else if (addr_en) begin
        if (idx < IW'(NB)) begin
          for (int k = 0; k < COL_BYTES; k++)
            if (idx == IW'(k)) col[8*k +: 8] <= bus_byte;
          for (int k = 0; k < ROW_BYTES; k++)
            if (idx == IW'(COL_BYTES + k)) row[8*k +: 8] <= bus_byte;
          idx <= idx + IW'(1);
        end
      end else if (col_step) begin
        col <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nfe_page_store.sv
module nfe_page_store
  import nfe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 16,
  localparam int CW = $clog2(PAGE_BYTES),
  localparam int RW = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_col,
  input  logic [7:0]    wr_byte,
  input  logic [CW-1:0] rd_col,
  output logic [7:0]    rd_byte,
  input  logic          op_go,
  input  op_t           op,
  input  logic [RW-1:0] page
);

  logic [7:0] cells [PAGES][PAGE_BYTES];
  logic [7:0] pbuf  [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++)
        for (int c = 0; c < PAGE_BYTES; c++)
          cells[p][c] <= 8'hFF;
      for (int c = 0; c < PAGE_BYTES; c++)
        pbuf[c] <= 8'hFF;
    end else begin
      if (op_go) begin
        unique case (op)
          OP_FETCH: for (int c = 0; c < PAGE_BYTES; c++) pbuf[c] <= cells[page][c];
          OP_WRITE: for (int c = 0; c < PAGE_BYTES; c++) cells[page][c] <= pbuf[c];
          OP_WIPE:  for (int c = 0; c < PAGE_BYTES; c++) cells[page][c] <= 8'hFF;
          default: ;
        endcase
      end else if (wr_en) begin
        pbuf[wr_col] <= wr_byte;
      end
    end
  end

  assign rd_byte = pbuf[rd_col];

endmodule

// File: rtl/nfe_bus_front.sv
module nfe_bus_front
  import nfe_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 16,
  parameter int COL_BYTES  = 1,
  parameter int ROW_BYTES  = 1,
  parameter int TIMER_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               cle,
  input  logic               ale,
  input  logic               we_n,
  input  logic               re_n,
  input  logic               wp_n,
  input  logic [7:0]         io_in,
  input  logic [TIMER_W-1:0] busy_len,
  output logic [7:0]         io_out,
  output logic               io_oe,
  output logic               rb_pull_low,
  output logic               standby
);

  localparam int CW = $clog2(PAGE_BYTES);
  localparam int RW = $clog2(PAGES);

  cyc_t       cyc;
  logic [7:0] bus_byte;
  logic       re_fall, re_low, ce_low, wp_ok;

  nfe_pin_sampler u_pins (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
    .cyc(cyc), .bus_byte(bus_byte), .re_fall(re_fall), .re_low(re_low),
    .ce_low(ce_low), .wp_ok(wp_ok)
  );

  logic busy, done, op_start;

  nfe_busy_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(op_start), .len(busy_len),
    .busy(busy), .done(done)
  );

  phase_t phase, phase_nx;
  op_t    pend_op, start_kind;
  logic   cmd_hit, rows_only, addr_wipe, addr_en, data_en, out_data, out_stat;
  logic [8*COL_BYTES-1:0] col;
  logic [8*ROW_BYTES-1:0] row_full;

  always_comb begin
    phase_nx   = phase;
    start_kind = OP_NONE;
    cmd_hit    = 1'b0;
    rows_only  = 1'b0;
    addr_wipe  = 1'b0;
    addr_en    = 1'b0;
    data_en    = 1'b0;
    out_data   = 1'b0;
    out_stat   = 1'b0;
    if (cyc == CYC_CMD && (!busy || bus_byte == OPC_STATUS)) begin
      cmd_hit = 1'b1;
      unique case (bus_byte)
        OPC_READ: begin
          phase_nx  = PH_RD_ADDR;
          addr_wipe = 1'b1;
        end
        OPC_PROG: begin
          phase_nx  = PH_PG_LOAD;
          addr_wipe = 1'b1;
        end
        OPC_ERASE: begin
          phase_nx  = PH_ER_ADDR;
          addr_wipe = 1'b1;
          rows_only = 1'b1;
        end
        OPC_STATUS: phase_nx = PH_STAT_OUT;
        OPC_READ_GO: begin
          phase_nx = PH_IDLE;
          if (phase == PH_RD_ADDR) start_kind = OP_FETCH;
        end
        OPC_PROG_GO: begin
          phase_nx = PH_IDLE;
          if (phase == PH_PG_LOAD && wp_ok) start_kind = OP_WRITE;
        end
        OPC_ERASE_GO: begin
          phase_nx = PH_IDLE;
          if (phase == PH_ER_ADDR && wp_ok) start_kind = OP_WIPE;
        end
        default: phase_nx = PH_IDLE;
      endcase
    end else if (!busy && cyc == CYC_ADDR) begin
      addr_en = (phase == PH_RD_ADDR) || (phase == PH_PG_LOAD) || (phase == PH_ER_ADDR);
    end else if (!busy && cyc == CYC_DATA) begin
      data_en = (phase == PH_PG_LOAD);
    end
    if (re_fall && !busy && phase == PH_DATA_OUT) out_data = 1'b1;
    if (re_fall && phase == PH_STAT_OUT)          out_stat = 1'b1;
    if (done && pend_op == OP_FETCH && phase_nx == PH_IDLE) phase_nx = PH_DATA_OUT;
  end

  assign op_start = (start_kind != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      pend_op <= OP_NONE;
    end else begin
      phase <= phase_nx;
      if (op_start)  pend_op <= start_kind;
      else if (done) pend_op <= OP_NONE;
    end
  end

  nfe_addr_unit #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .seq_restart(cmd_hit), .seq_rows_only(rows_only),
    .addr_wipe(addr_wipe), .addr_en(addr_en), .bus_byte(bus_byte),
    .col_step(data_en | out_data), .col(col), .row(row_full)
  );

  logic unused_addr_hi;
  assign unused_addr_hi = ^row_full;

  logic [7:0] rd_byte;

  nfe_page_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(data_en), .wr_col(col[CW-1:0]),
    .wr_byte(bus_byte), .rd_col(col[CW-1:0]), .rd_byte(rd_byte),
    .op_go(done), .op(pend_op), .page(row_full[RW-1:0])
  );

  logic [7:0] out_q;
  logic [7:0] stat_byte;
  assign stat_byte = {wp_ok, ~busy, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_q <= 8'h00;
    else if (out_data) out_q <= rd_byte;
    else if (out_stat) out_q <= stat_byte;
  end

  assign io_out      = out_q;
  assign io_oe       = ce_low & re_low & ((phase == PH_DATA_OUT) | (phase == PH_STAT_OUT));
  assign rb_pull_low = busy;
  assign standby     = ~ce_low & ~busy;

endmodule

// File: rtl/nfe_bus_front_chk.sv
module nfe_bus_front_chk #(
  parameter int TIMER_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_n,
  input logic               re_n,
  input logic [TIMER_W-1:0] busy_len,
  input logic               io_oe,
  input logic               rb_pull_low,
  input logic               standby
);

  assert_standby_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !rb_pull_low);

  assert_oe_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> ($past(!ce_n) && $past(!re_n)));

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rb_pull_low) && $stable(busy_len) && busy_len > TIMER_W'(1)) |=> rb_pull_low);

  assert_busy_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rb_pull_low) && $stable(busy_len) && busy_len <= TIMER_W'(1)) |=> !rb_pull_low);

endmodule

bind nfe_bus_front nfe_bus_front_chk #(.TIMER_W(TIMER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .re_n(re_n), .busy_len(busy_len),
  .io_oe(io_oe), .rb_pull_low(rb_pull_low), .standby(standby)
);

// File: tb/sim_nfe_bus_front.sv
module sim_nfe_bus_front;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = 8'h00;
  logic [7:0] busy_len = 8'd3;
  logic [7:0] io_out;
  logic io_oe, rb_pull_low, standby;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nfe_bus_front u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .busy_len(busy_len),
    .io_out(io_out), .io_oe(io_oe), .rb_pull_low(rb_pull_low), .standby(standby)
  );

  function automatic logic [7:0] pat(int p, int c);
    return 8'((p * 37 + c * 5 + 1) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic c, logic a, logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; io_in = b; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(logic [7:0] b);  send(1'b1, 1'b0, b); endtask
  task automatic adr(logic [7:0] b);  send(1'b0, 1'b1, b); endtask
  task automatic dat(logic [7:0] b);  send(1'b0, 1'b0, b); endtask

  task automatic wait_ready();
    while (rb_pull_low) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v, output logic oe);
    @(negedge clk);
    re_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    v = io_out; oe = io_oe;
    re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic open_page(int p, int c);
    cmd(8'h00); adr(8'(c)); adr(8'(p)); cmd(8'h30);
    wait_ready();
  endtask

  initial begin
    logic [7:0] v;
    logic oe;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R13 reset state, R11 standby with chip select high
    check("R13 ready after reset", {31'd0, rb_pull_low}, 0);
    check("R13 oe after reset", {31'd0, io_oe}, 0);
    check("R11 standby when deselected and ready", {31'd0, standby}, 1);
    ce_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 standby cleared by select", {31'd0, standby}, 0);
    open_page(0, 0);
    for (int i = 0; i < 4; i++) begin
      rd(v, oe);
      check("R13 erased after reset", {24'd0, v}, 32'hFF);
    end

    // R4 R6: program all pages
    for (int p = 0; p < 4; p++) begin
      cmd(8'h80); adr(8'h00); adr(8'(p));
      for (int c = 0; c < 16; c++) dat(pat(p, c));
      cmd(8'h10);
      check("R6 program busy", {31'd0, rb_pull_low}, 1);
      wait_ready();
    end

    // R5 sweep of reads with wrap
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 16; s += 7) begin
        open_page(p, s);
        for (int i = 0; i < 18; i++) begin
          rd(v, oe);
          check("R5 read byte", {24'd0, v}, {24'd0, pat(p, (s + i) % 16)});
          check("R12 oe during data out", {31'd0, oe}, 1);
        end
      end
    end

    // R6 busy length sweep
    for (int L = 0; L < 8; L++) begin
      busy_len = 8'(L);
      cmd(8'h00); adr(8'h00); adr(8'h00); cmd(8'h30);
      n = 0;
      while (rb_pull_low) begin n++; @(negedge clk); end
      check("R6 busy length", n, (L == 0) ? 1 : L);
    end
    busy_len = 8'd3;

    // R2 both selects high is ignored
    cmd(8'h00); adr(8'h02); adr(8'h01);
    send(1'b1, 1'b1, 8'h30);
    check("R2 illegal cycle starts nothing", {31'd0, rb_pull_low}, 0);
    adr(8'h05);
    cmd(8'h30);
    check("R2 read still armed", {31'd0, rb_pull_low}, 1);
    wait_ready();
    rd(v, oe);
    check("R2 address unaffected", {24'd0, v}, {24'd0, pat(1, 2)});

    // R1 unknown command leaves idle, go outside setup starts nothing
    cmd(8'h00); adr(8'h00); adr(8'h00); cmd(8'h55); cmd(8'h30);
    check("R1 go after unknown code", {31'd0, rb_pull_low}, 0);
    cmd(8'hD0);
    check("R1 erase go without setup", {31'd0, rb_pull_low}, 0);

    // R3 surplus address bytes ignored
    cmd(8'h00); adr(8'h04); adr(8'h02); adr(8'h09); cmd(8'h30);
    wait_ready();
    rd(v, oe);
    check("R3 surplus address ignored", {24'd0, v}, {24'd0, pat(2, 4)});
    // R3 sequence restarts on a new command
    cmd(8'h00); adr(8'h07); cmd(8'h00); adr(8'h03); adr(8'h01); cmd(8'h30);
    wait_ready();
    rd(v, oe);
    check("R3 sequence restart", {24'd0, v}, {24'd0, pat(1, 3)});

    // R7 write cycles ignored while busy
    busy_len = 8'd60;
    cmd(8'h00); adr(8'h05); adr(8'h03); cmd(8'h30);
    cmd(8'h60); adr(8'h01); cmd(8'hD0);
    check("R7 still busy from read", {31'd0, rb_pull_low}, 1);
    wait_ready();
    rd(v, oe);
    check("R7 read completes intact", {24'd0, v}, {24'd0, pat(3, 5)});
    busy_len = 8'd3;
    open_page(1, 0);
    rd(v, oe);
    check("R7 erase during busy dropped", {24'd0, v}, {24'd0, pat(1, 0)});

    // R8 status during and after busy
    busy_len = 8'd40;
    cmd(8'h00); adr(8'h00); adr(8'h01); cmd(8'h30);
    cmd(8'h70);
    rd(v, oe);
    check("R8 status while busy", {24'd0, v}, 32'h80);
    check("R12 oe in status out", {31'd0, oe}, 1);
    // R11 chip select high while busy
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 no standby while busy", {31'd0, standby}, 0);
    check("R11 busy continues", {31'd0, rb_pull_low}, 1);
    wait_ready();
    check("R11 standby once ready", {31'd0, standby}, 1);
    ce_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd(v, oe);
    check("R8 status when ready", {24'd0, v}, 32'hC0);
    busy_len = 8'd3;

    // R12 output enable gating, chip select gates the column step
    open_page(2, 6);
    check("R12 oe with read strobe high", {31'd0, io_oe}, 0);
    rd(v, oe);
    check("R5 first byte", {24'd0, v}, {24'd0, pat(2, 6)});
    ce_n = 1'b1;
    @(negedge clk);
    re_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 oe with chip select high", {31'd0, io_oe}, 0);
    re_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk);
    rd(v, oe);
    check("R5 no step while deselected", {24'd0, v}, {24'd0, pat(2, 7)});

    // R9 write protect
    wp_n = 1'b0;
    cmd(8'h80); adr(8'h00); adr(8'h01); dat(8'hAA); dat(8'h55); cmd(8'h10);
    check("R9 program blocked", {31'd0, rb_pull_low}, 0);
    cmd(8'h60); adr(8'h01); cmd(8'hD0);
    check("R9 erase blocked", {31'd0, rb_pull_low}, 0);
    cmd(8'h70);
    rd(v, oe);
    check("R8 status shows protect", {24'd0, v}, 32'h40);
    wp_n = 1'b1;
    @(negedge clk);
    open_page(1, 0);
    rd(v, oe);
    check("R9 page kept byte 0", {24'd0, v}, {24'd0, pat(1, 0)});
    rd(v, oe);
    check("R9 page kept byte 1", {24'd0, v}, {24'd0, pat(1, 1)});

    // R10 erase page 2, R3 erase takes row bytes only
    cmd(8'h60); adr(8'h02); cmd(8'hD0);
    check("R10 erase busy", {31'd0, rb_pull_low}, 1);
    wait_ready();
    open_page(2, 0);
    for (int i = 0; i < 16; i++) begin
      rd(v, oe);
      check("R10 erased byte", {24'd0, v}, 32'hFF);
    end
    open_page(0, 0);
    rd(v, oe);
    check("R3 erase row-only, page 0 kept", {24'd0, v}, {24'd0, pat(0, 0)});
    open_page(3, 9);
    rd(v, oe);
    check("R10 other page kept", {24'd0, v}, {24'd0, pat(3, 9)});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule